// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between a set of internally generated clocks and the clock pins of a clock-generator device. It gates each derived clock so that a processor group and a PCI group can be halted at logic 0 by their own active-low stop inputs. A per-output configuration bit lets selected outputs ignore the stop request. Each group also has one dedicated output that is never gated by its stop input. A single PCI output can run at either the base PCI rate or twice that rate. All gating is made glitch-free: every enable is brought into its own clock domain and changes only while that clock is low.

One pin serves two purposes. After reset it is a power-good input. Its first rising edge captures the frequency-select straps, which are then held. From that point on the same pin is an active-low power-down request. Power-down drops an oscillator-enable output and silences every clock output. When the request is released, the outputs stay off for a programmable number of reference cycles while the oscillator settles. The straps are not captured again. A reset applied before power-good rises returns the pin to its power-good role.

Top module: `clkgate_pwr_ctrl`

## Requirements
- R1: While `pci_stop_n` is 0, every `pci_clk_o[i]` whose `pci_free_cfg[i]` is 0 stays at 0. While `pci_stop_n` is 1, every PCI output toggles.
- R2: While `cpu_stop_n` is 0, every `cpu_clk_o[i]` whose `cpu_free_cfg[i]` is 0 stays at 0. While `cpu_stop_n` is 1, every processor output toggles.
- R3: A configuration bit of 1 (`cpu_free_cfg[i]`, `pci_free_cfg[i]`, or `pcisel_free_cfg` for the selectable output) keeps that output toggling whatever its group's stop input does.
- R4: `cpu_free_clk_o` and `pci_free_clk_o` toggle whenever the block is running, regardless of either stop input.
- R5: On the first rise of `pwrgd_pd_n` after reset, `fs_strap` is copied to `fs_latched` and `straps_valid` goes to 1. Both then hold, whatever `fs_strap` does later.
- R6: Once `straps_valid` is 1, `pwrgd_pd_n` held at 0 drives `osc_en` to 0 within 2 reference cycles, and every clock output, including the free-running ones, stays at 0.
- R7: `pcisel_clk_o` follows `pci_src_clk` when `pci_dbl_sel` is 0 and `pci2x_src_clk` (twice the rate) when it is 1. Switching between the two produces no runt pulse.
- R8: After power-down is released, `osc_en` returns to 1 within 2 reference cycles. Every clock output stays at 0 for at least `settle_len` reference cycles. `fs_latched` is not recaptured.
- R9: Each gating enable changes only while its source clock is low.
- R10: Reset clears `fs_latched` to 0 and `straps_valid` to 0, holds all clock outputs at 0, and keeps `osc_en` at 1. Before straps are captured, a low level on `pwrgd_pd_n` is not treated as power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the pin logic and settle counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_pd_n | input | 1 | Power-good before capture; active-low power-down after |
| fs_strap | input | FS_W | Frequency-select strap levels |
| settle_len | input | SETTLE_W | Reference cycles to keep outputs off after power-down |
| cpu_src_clk | input | 1 | Processor source clock |
| pci_src_clk | input | 1 | Base PCI source clock |
| pci2x_src_clk | input | 1 | Double-rate PCI source clock |
| cpu_stop_n | input | 1 | Active-low processor stop request |
| pci_stop_n | input | 1 | Active-low PCI stop request |
| cpu_free_cfg | input | N_CPU | 1 = processor output ignores stop |
| pci_free_cfg | input | N_PCI | 1 = PCI output ignores stop |
| pcisel_free_cfg | input | 1 | 1 = selectable PCI output ignores stop |
| pci_dbl_sel | input | 1 | 1 = selectable PCI output at double rate |
| osc_en | output | 1 | Oscillator enable |
| straps_valid | output | 1 | Straps have been captured |
| fs_latched | output | FS_W | Captured strap values |
| cpu_clk_o | output | N_CPU | Stoppable processor clocks |
| cpu_free_clk_o | output | 1 | Free-running processor clock |
| pci_clk_o | output | N_PCI | Stoppable PCI clocks |
| pci_free_clk_o | output | 1 | Free-running PCI clock |
| pcisel_clk_o | output | 1 | PCI clock at selectable rate |

## Verification
The assertions assume three things about the inputs. Every source clock keeps toggling while reset is released. `pwrgd_pd_n` is held for at least two reference cycles once it changes. The straps are steady around the power-good rise. The stimulus changes inputs just after a reference edge and moves the pin only in long steps. It leaves all source clocks free-running throughout, so every synchronizer sees settled levels. Gated outputs are judged by counting their rising edges over windows of many reference cycles, opened well after each change.

// File: rtl/clkgate_pwr_ctrl.sv
module clkgate_pwr_ctrl #(
  parameter int N_CPU    = 2,
  parameter int N_PCI    = 6,
  parameter int FS_W     = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  input  logic                pwrgd_pd_n,
  input  logic [FS_W-1:0]     fs_strap,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                cpu_src_clk,
  input  logic                pci_src_clk,
  input  logic                pci2x_src_clk,
  input  logic                cpu_stop_n,
  input  logic                pci_stop_n,
  input  logic [N_CPU-1:0]    cpu_free_cfg,
  input  logic [N_PCI-1:0]    pci_free_cfg,
  input  logic                pcisel_free_cfg,
  input  logic                pci_dbl_sel,
  output logic                osc_en,
  output logic                straps_valid,
  output logic [FS_W-1:0]     fs_latched,
  output logic [N_CPU-1:0]    cpu_clk_o,
  output logic                cpu_free_clk_o,
  output logic [N_PCI-1:0]    pci_clk_o,
  output logic                pci_free_clk_o,
  output logic                pcisel_clk_o
);
  localparam int CW = N_CPU + 1;
  localparam int PW = N_PCI + 1;

  logic pg_s1, pg_s2, armed, run_q;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [FS_W-1:0] fs_q;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      pg_s1 <= 1'b0;
      pg_s2 <= 1'b0;
      armed <= 1'b0;
      fs_q <= '0;
      settle_cnt <= '0;
      run_q <= 1'b0;
    end else begin
      pg_s1 <= pwrgd_pd_n;
      pg_s2 <= pg_s1;
      if (!armed && pg_s2) begin
        armed <= 1'b1;
        fs_q <= fs_strap;
      end
      if (!(armed && pg_s2))
        settle_cnt <= settle_len;
      else if (settle_cnt != '0)
        settle_cnt <= settle_cnt - 1'b1;
      run_q <= armed && pg_s2 && (settle_cnt == '0);
    end

  assign osc_en = !armed || pg_s2;
  assign straps_valid = armed;
  assign fs_latched = fs_q;

  logic [CW-1:0] cpu_want, cpu_s1, cpu_s2, cpu_en;
  assign cpu_want = {run_q, {N_CPU{run_q}} & (cpu_free_cfg | {N_CPU{cpu_stop_n}})};

  always_ff @(posedge cpu_src_clk or negedge rst_n)
    if (!rst_n) begin
      cpu_s1 <= '0;
      cpu_s2 <= '0;
    end else begin
      cpu_s1 <= cpu_want;
      cpu_s2 <= cpu_s1;
    end

  always_ff @(negedge cpu_src_clk or negedge rst_n)
    if (!rst_n) cpu_en <= '0;
    else        cpu_en <= cpu_s2;

  assign cpu_clk_o = {N_CPU{cpu_src_clk}} & cpu_en[N_CPU-1:0];
  assign cpu_free_clk_o = cpu_src_clk & cpu_en[N_CPU];

  logic sel_want, a_en, b_en;
  logic [PW-1:0] pci_want, pci_s1, pci_s2, pci_en;
  logic a_s1, a_s2, b_s1, b_s2;
  assign pci_want = {run_q, {N_PCI{run_q}} & (pci_free_cfg | {N_PCI{pci_stop_n}})};
  assign sel_want = run_q && (pcisel_free_cfg || pci_stop_n);

  always_ff @(posedge pci_src_clk or negedge rst_n)
    if (!rst_n) begin
      pci_s1 <= '0;
      pci_s2 <= '0;
      a_s1 <= 1'b0;
      a_s2 <= 1'b0;
    end else begin
      pci_s1 <= pci_want;
      pci_s2 <= pci_s1;
      a_s1 <= sel_want && !pci_dbl_sel && !b_en;
      a_s2 <= a_s1;
    end

  always_ff @(negedge pci_src_clk or negedge rst_n)
    if (!rst_n) begin
      pci_en <= '0;
      a_en <= 1'b0;
    end else begin
      pci_en <= pci_s2;
      a_en <= a_s2;
    end

  always_ff @(posedge pci2x_src_clk or negedge rst_n)
    if (!rst_n) begin
      b_s1 <= 1'b0;
      b_s2 <= 1'b0;
    end else begin
      b_s1 <= sel_want && pci_dbl_sel && !a_en;
      b_s2 <= b_s1;
    end

  always_ff @(negedge pci2x_src_clk or negedge rst_n)
    if (!rst_n) b_en <= 1'b0;
    else        b_en <= b_s2;

  assign pci_clk_o = {N_PCI{pci_src_clk}} & pci_en[N_PCI-1:0];
  assign pci_free_clk_o = pci_src_clk & pci_en[N_PCI];
  assign pcisel_clk_o = (pci_src_clk & a_en) | (pci2x_src_clk & b_en);

endmodule

module clkgate_pwr_ctrl_chk #(
  parameter int N_CPU = 2,
  parameter int FS_W  = 4
) (
  input logic            ref_clk,
  input logic            rst_n,
  input logic            pwrgd_pd_n,
  input logic            osc_en,
  input logic            straps_valid,
  input logic [FS_W-1:0] fs_latched,
  input logic            cpu_src_clk,
  input logic [N_CPU:0]  cpu_en,
  input logic            cpu_free_clk_o,
  input logic            pci_src_clk,
  input logic            pci2x_src_clk,
  input logic            a_en,
  input logic            b_en
);
  p_pd_osc_off_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (straps_valid && !pwrgd_pd_n && $past(!pwrgd_pd_n)) |=> !osc_en);

  p_straps_hold_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (straps_valid && $past(straps_valid)) |-> $stable(fs_latched));

  p_straps_no_drop_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$fell(straps_valid));

  p_free_cpu_high_r4: assert property (@(negedge cpu_src_clk) disable iff (!rst_n)
    cpu_en[N_CPU] |-> cpu_free_clk_o);

  p_sel_exclusive_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(a_en && b_en));

  always @(cpu_en)
    if (rst_n) p_cpu_gate_low_r9: assert (!cpu_src_clk);

  always @(a_en)
    if (rst_n) p_sel_a_gate_low_r9: assert (!pci_src_clk);

  always @(b_en)
    if (rst_n) p_sel_b_gate_low_r9: assert (!pci2x_src_clk);
endmodule

bind clkgate_pwr_ctrl clkgate_pwr_ctrl_chk #(.N_CPU(N_CPU), .FS_W(FS_W)) chk_i (
  .ref_clk(ref_clk), .rst_n(rst_n), .pwrgd_pd_n(pwrgd_pd_n), .osc_en(osc_en),
  .straps_valid(straps_valid), .fs_latched(fs_latched), .cpu_src_clk(cpu_src_clk),
  .cpu_en(cpu_en), .cpu_free_clk_o(cpu_free_clk_o), .pci_src_clk(pci_src_clk),
  .pci2x_src_clk(pci2x_src_clk), .a_en(a_en), .b_en(b_en)
);

// File: tb/clkgate_pwr_ctrl_tb_top.sv
module clkgate_pwr_ctrl_tb_top;
  localparam int NC = 2;
  localparam int NP = 6;
  localparam int FW = 4;
  localparam int SW = 8;

  logic ref_clk = 0, cpu_src_clk = 0, pci_src_clk = 0, pci2x_src_clk = 0;
  always #4 ref_clk = ~ref_clk;
  always #3 cpu_src_clk = ~cpu_src_clk;
  always #8 pci_src_clk = ~pci_src_clk;
  initial begin #1; forever #4 pci2x_src_clk = ~pci2x_src_clk; end

  logic rst_n, pwrgd_pd_n, cpu_stop_n, pci_stop_n, pcisel_free_cfg, pci_dbl_sel;
  logic [FW-1:0] fs_strap;
  logic [SW-1:0] settle_len;
  logic [NC-1:0] cpu_free_cfg;
  logic [NP-1:0] pci_free_cfg;
  logic osc_en, straps_valid, cpu_free_clk_o, pci_free_clk_o, pcisel_clk_o;
  logic [FW-1:0] fs_latched;
  logic [NC-1:0] cpu_clk_o;
  logic [NP-1:0] pci_clk_o;

  clkgate_pwr_ctrl #(.N_CPU(NC), .N_PCI(NP), .FS_W(FW), .SETTLE_W(SW)) dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .pwrgd_pd_n(pwrgd_pd_n), .fs_strap(fs_strap),
    .settle_len(settle_len), .cpu_src_clk(cpu_src_clk), .pci_src_clk(pci_src_clk),
    .pci2x_src_clk(pci2x_src_clk), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_free_cfg(cpu_free_cfg), .pci_free_cfg(pci_free_cfg),
    .pcisel_free_cfg(pcisel_free_cfg), .pci_dbl_sel(pci_dbl_sel), .osc_en(osc_en),
    .straps_valid(straps_valid), .fs_latched(fs_latched), .cpu_clk_o(cpu_clk_o),
    .cpu_free_clk_o(cpu_free_clk_o), .pci_clk_o(pci_clk_o),
    .pci_free_clk_o(pci_free_clk_o), .pcisel_clk_o(pcisel_clk_o));

  int cpu_cnt [NC] = '{default: 0};
  int pci_cnt [NP] = '{default: 0};
  int cf_cnt = 0, pf_cnt = 0, sel_cnt = 0;
  for (genvar g = 0; g < NC; g++) begin : g_cc
    always @(posedge cpu_clk_o[g]) cpu_cnt[g] = cpu_cnt[g] + 1;
  end
  for (genvar g = 0; g < NP; g++) begin : g_pc
    always @(posedge pci_clk_o[g]) pci_cnt[g] = pci_cnt[g] + 1;
  end
  always @(posedge cpu_free_clk_o) cf_cnt = cf_cnt + 1;
  always @(posedge pci_free_clk_o) pf_cnt = pf_cnt + 1;
  always @(posedge pcisel_clk_o) sel_cnt = sel_cnt + 1;

  int d_cpu [NC];
  int d_pci [NP];
  int d_cf, d_pf, d_sel;
  int n_chk = 0, n_bad = 0;

  // {cpu_stop_n, pci_stop_n, cpu_free[1:0], pci_free[5:0], sel_free, dbl, exp_cpu[1:0], exp_pci[5:0], exp_sel}
  localparam logic [20:0] VEC [7] = '{
    21'b1_1_00_000000_0_0_11_111111_1,
    21'b0_1_01_000000_0_0_01_111111_1,
    21'b1_0_00_101001_0_0_11_101001_0,
    21'b0_0_10_010110_1_1_10_010110_1,
    21'b0_0_00_000000_0_1_00_000000_0,
    21'b1_1_11_111111_0_1_11_111111_1,
    21'b1_1_00_000000_0_0_11_111111_1
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_edges(input string req, input string what, input int d, input bit on);
    n_chk++;
    if (on ? (d == 0) : (d != 0)) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d edges expected %s", req, what, d, on ? ">0" : "0");
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic measure(input int n);
    int s_cpu [NC];
    int s_pci [NP];
    int s_cf, s_pf, s_sel;
    s_cpu = cpu_cnt; s_pci = pci_cnt; s_cf = cf_cnt; s_pf = pf_cnt; s_sel = sel_cnt;
    cyc(n);
    for (int i = 0; i < NC; i++) d_cpu[i] = cpu_cnt[i] - s_cpu[i];
    for (int i = 0; i < NP; i++) d_pci[i] = pci_cnt[i] - s_pci[i];
    d_cf = cf_cnt - s_cf; d_pf = pf_cnt - s_pf; d_sel = sel_cnt - s_sel;
  endtask

  task automatic all_quiet(input string req);
    for (int i = 0; i < NC; i++) chk_edges(req, $sformatf("cpu_clk_o[%0d]", i), d_cpu[i], 0);
    for (int i = 0; i < NP; i++) chk_edges(req, $sformatf("pci_clk_o[%0d]", i), d_pci[i], 0);
    chk_edges(req, "cpu_free_clk_o", d_cf, 0);
    chk_edges(req, "pci_free_clk_o", d_pf, 0);
    chk_edges(req, "pcisel_clk_o", d_sel, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; pwrgd_pd_n = 0; fs_strap = 4'b0101; settle_len = 8'd20;
    cpu_stop_n = 1; pci_stop_n = 1; cpu_free_cfg = '0; pci_free_cfg = '0;
    pcisel_free_cfg = 0; pci_dbl_sel = 0;
    cyc(5); rst_n = 1; cyc(5);
    @(negedge ref_clk);
    chk(straps_valid == 0, "R10", "straps_valid after reset", straps_valid, 0);
    chk(fs_latched == 0, "R10", "fs_latched after reset", fs_latched, 0);
    chk(osc_en == 1, "R10", "osc_en with pin low before capture", osc_en, 1);
    measure(16);
    all_quiet("R10");

    pwrgd_pd_n = 1; cyc(40);
    @(negedge ref_clk);
    chk(straps_valid == 1, "R5", "straps_valid after power-good", straps_valid, 1);
    chk(fs_latched == 4'b0101, "R5", "fs_latched captured", fs_latched, 5);
    fs_strap = 4'b1010; cyc(5);
    @(negedge ref_clk);
    chk(fs_latched == 4'b0101, "R5", "fs_latched held after strap change", fs_latched, 5);

    for (int v = 0; v < 7; v++) begin
      logic [20:0] e;
      e = VEC[v];
      @(posedge ref_clk); #1;
      cpu_stop_n = e[20]; pci_stop_n = e[19]; cpu_free_cfg = e[18:17];
      pci_free_cfg = e[16:11]; pcisel_free_cfg = e[10]; pci_dbl_sel = e[9];
      cyc(12);
      measure(16);
      for (int i = 0; i < NC; i++)
        chk_edges(e[20] ? "R2" : "R2/R3", $sformatf("vec%0d cpu_clk_o[%0d]", v, i), d_cpu[i], e[7+i]);
      for (int i = 0; i < NP; i++)
        chk_edges(e[19] ? "R1" : "R1/R3", $sformatf("vec%0d pci_clk_o[%0d]", v, i), d_pci[i], e[1+i]);
      chk_edges("R3", $sformatf("vec%0d pcisel_clk_o", v), d_sel, e[0]);
      chk_edges("R4", $sformatf("vec%0d cpu_free_clk_o", v), d_cf, 1);
      chk_edges("R4", $sformatf("vec%0d pci_free_clk_o", v), d_pf, 1);
      if (e[0]) begin
        if (e[9]) chk(d_sel >= 12, "R7", $sformatf("vec%0d double-rate edges", v), d_sel, 16);
        else      chk(d_sel >= 6 && d_sel <= 10, "R7", $sformatf("vec%0d base-rate edges", v), d_sel, 8);
      end
    end

    pwrgd_pd_n = 0;
    @(posedge ref_clk); @(posedge ref_clk); @(negedge ref_clk);
    chk(osc_en == 0, "R6", "osc_en 2 cycles after power-down", osc_en, 0);
    cyc(4);
    measure(16);
    all_quiet("R6");

    pwrgd_pd_n = 1;
    cyc(3);
    @(negedge ref_clk);
    chk(osc_en == 1, "R8", "osc_en after release", osc_en, 1);
    measure(15);
    all_quiet("R8");
    cyc(30);
    measure(16);
    chk_edges("R8", "cpu_clk_o[0] after settle", d_cpu[0], 1);
    chk_edges("R8", "pci_free_clk_o after settle", d_pf, 1);
    @(negedge ref_clk);
    chk(fs_latched == 4'b0101, "R8", "fs_latched not recaptured", fs_latched, 5);

    pwrgd_pd_n = 0; rst_n = 0; cyc(3); rst_n = 1; cyc(5);
    @(negedge ref_clk);
    chk(straps_valid == 0, "R10", "straps_valid after second reset", straps_valid, 0);
    chk(fs_latched == 0, "R10", "fs_latched after second reset", fs_latched, 0);
    chk(osc_en == 1, "R10", "pin low is power-good role", osc_en, 1);
    measure(16);
    chk_edges("R10", "cpu_free_clk_o before power-good", d_cf, 0);
    fs_strap = 4'b0011; pwrgd_pd_n = 1; cyc(40);
    @(negedge ref_clk);
    chk(fs_latched == 4'b0011, "R10", "fs_latched recaptured after reset", fs_latched, 3);
    chk(straps_valid == 1, "R10", "straps_valid after new power-good", straps_valid, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule